// File: doc/BRIEF.md
# Partial-Field Word Load/Store Unit

This unit moves a contiguous slice of a sign-magnitude word between memory and a register. A word holds a sign bit and five 6-bit bytes. Positions are numbered 0 to 5: position 0 is the sign and positions 1 to 5 are the bytes, most significant first. A field is named by a left position L and a right position R, packed into one 6-bit code as 8L+R.

For a load, the selected bytes of the memory word are moved down to the least significant end of the result, and the bytes above them are cleared. The sign comes from memory only when position 0 is part of the field, and a negated load flips that sign. For a store, the rightmost register bytes are placed into the field of the old memory word, and every byte outside the field is kept. The register operand can be a full word, a two-byte index register, or the jump register, which always has a plus sign. A store-zero mode writes plus zero into the field.

A request is taken in one cycle. The result and an error flag are registered, and a valid strobe marks them in the following cycle. A small controller has two states. In ST_IDLE no result is presented. In ST_RESP the registered result is valid. The transition to ST_RESP happens on any cycle with a request. The transition to ST_IDLE happens on any cycle without one. Back-to-back requests keep the controller in ST_RESP.

Top module: `pf_lsu`

## Requirements
- R1: The field code splits into L = code[5:3] and R = code[2:0]. The code is legal only when L <= R and R <= 5.
- R2: A load with a legal field places memory bytes max(L,1)..R at result bytes (5-(R-max(L,1)))..5, keeping their order, and clears all other result bytes.
- R3: A load takes the memory sign (bit 30, 1 = minus) when L = 0, and gives plus otherwise.
- R4: A negated load (op 1) gives the opposite of the sign that a normal load (op 0) would give for the same inputs.
- R5: A store (op 2) with a legal field writes the rightmost R-max(L,1)+1 register bytes into memory bytes max(L,1)..R, keeping their order. All other memory bytes are unchanged.
- R6: A store replaces the memory sign with the register sign only when L = 0. Otherwise the memory sign is kept.
- R7: With kind 1 (index) or kind 2 (jump), register bytes 1..3 count as zero for a store, and result bytes 1..3 are zero for a load.
- R8: With kind 2 (jump), the register sign counts as plus for a store.
- R9: A store-zero (op 3) writes plus zero into the field, and treats the sign exactly like R6.
- R10: An illegal field code sets err_o. The result is then the unchanged destination: reg_word_i for a load, mem_word_i for a store.
- R11: res_valid_o is high exactly in the cycle after a request. result_o and err_o are updated only by a request and otherwise hold their values. All three outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe |
| op_i | input | 2 | 0 load, 1 negated load, 2 store, 3 store zero |
| kind_i | input | 2 | Register kind: 0 full word, 1 index, 2 jump, 3 full word |
| field_i | input | 6 | Field code 8L+R |
| mem_word_i | input | 31 | Memory word; bit 30 is the sign, bits 29:24 are byte 1, bits 5:0 are byte 5 |
| reg_word_i | input | 31 | Register word, same layout as the memory word |
| res_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 31 | New register value (load) or merged memory word (store) |
| err_o | output | 1 | Illegal field code flag |

## Verification
The clocked properties relate an output to the inputs of the request one cycle earlier. They therefore assume that op_i, kind_i, field_i and both words are stable and defined at each edge where req_i is high. They also assume that no request is pending across reset. The stimulus meets these assumptions by changing every input only at the falling edge, and by holding req_i low while reset is active. Every field code, including the illegal ones, is sent with every operation, so the properties on sign handling and destination hold are exercised in both the legal and the illegal case.

// File: rtl/pflsu_pkg.sv
package pflsu_pkg;
    parameter int BYTE_W    = 6;
    parameter int NBYTES    = 5;
    parameter int IDX_BYTES = 2;
    localparam int MAG_W    = NBYTES * BYTE_W;
    localparam int WORD_W   = MAG_W + 1;
    localparam int POS_W    = $clog2(NBYTES + 1);
    localparam int FCODE_W  = 2 * POS_W;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic                neg;
        byte_t [1:NBYTES]    b;
    } word_t;

    typedef enum logic [1:0] {
        OP_LOAD       = 2'd0,
        OP_LOAD_NEG   = 2'd1,
        OP_STORE      = 2'd2,
        OP_STORE_ZERO = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        KIND_WORD  = 2'd0,
        KIND_INDEX = 2'd1,
        KIND_JUMP  = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } state_e;
endpackage

// File: rtl/pflsu_field_decode.sv
module pflsu_field_decode
    import pflsu_pkg::*;
(
    input  logic [FCODE_W-1:0] code,
    output logic [POS_W-1:0]   left,
    output logic [POS_W-1:0]   right,
    output logic [POS_W-1:0]   first_byte,
    output logic               legal
);
    assign left       = code[FCODE_W-1 -: POS_W];
    assign right      = code[POS_W-1:0];
    // the sign position is not a byte, so byte work starts at position 1
    assign first_byte = (left == '0) ? POS_W'(1) : left;
    assign legal      = (left <= right) && (int'(right) <= NBYTES);
endmodule

// File: rtl/pflsu_load_extract.sv
module pflsu_load_extract
    import pflsu_pkg::*;
(
    input  word_t            src_w,
    input  logic [POS_W-1:0] left,
    input  logic [POS_W-1:0] right,
    input  logic [POS_W-1:0] first_byte,
    input  logic             negate,
    input  logic             short_reg,
    output word_t            dst_w
);
    logic [MAG_W-1:0]  shifted;
    word_t             shw;
    byte_t [1:NBYTES]  out_b;
    int                first_kept;
    logic              sgn;

    always_comb begin
        shifted    = src_w.b >> (BYTE_W * (NBYTES - int'(right)));
        first_kept = NBYTES - int'(right) + int'(first_byte);
        sgn        = ((left == '0) ? src_w.neg : 1'b0) ^ negate;
    end

    assign shw = {1'b0, shifted};

    for (genvar p = 1; p <= NBYTES; p++) begin : g_byte
        logic keep;
        assign keep     = (p >= first_kept) && (!short_reg || (p > NBYTES - IDX_BYTES));
        assign out_b[p] = keep ? shw.b[p] : '0;
    end

    assign dst_w = {sgn, out_b};
endmodule

// File: rtl/pflsu_store_merge.sv
module pflsu_store_merge
    import pflsu_pkg::*;
(
    input  word_t            old_w,
    input  word_t            src_w,
    input  logic [POS_W-1:0] left,
    input  logic [POS_W-1:0] right,
    input  logic [POS_W-1:0] first_byte,
    output word_t            dst_w
);
    logic [MAG_W-1:0]  inserted;
    word_t             insw;
    byte_t [1:NBYTES]  out_b;
    logic              sgn;

    always_comb begin
        inserted = src_w.b << (BYTE_W * (NBYTES - int'(right)));
        sgn      = (left == '0) ? src_w.neg : old_w.neg;
    end

    assign insw = {1'b0, inserted};

    for (genvar p = 1; p <= NBYTES; p++) begin : g_byte
        logic in_field;
        assign in_field = (p >= int'(first_byte)) && (p <= int'(right));
        assign out_b[p] = in_field ? insw.b[p] : old_w.b[p];
    end

    assign dst_w = {sgn, out_b};
endmodule

// File: rtl/pf_lsu.sv
module pf_lsu
    import pflsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [1:0]         op_i,
    input  logic [1:0]         kind_i,
    input  logic [FCODE_W-1:0] field_i,
    input  logic [WORD_W-1:0]  mem_word_i,
    input  logic [WORD_W-1:0]  reg_word_i,
    output logic               res_valid_o,
    output logic [WORD_W-1:0]  result_o,
    output logic               err_o
);
    op_e              op;
    kind_e            kind;
    logic             is_store, short_reg, legal;
    logic [POS_W-1:0] left, right, first_byte;
    word_t            mem_w, reg_w, st_src, ld_w, st_w, next_res;
    state_e           state_q, state_d;
    logic [WORD_W-1:0] result_q;
    logic             err_q;

    assign op        = op_e'(op_i);
    assign kind      = kind_e'(kind_i);
    assign mem_w     = mem_word_i;
    assign reg_w     = reg_word_i;
    assign is_store  = (op == OP_STORE) || (op == OP_STORE_ZERO);
    assign short_reg = (kind == KIND_INDEX) || (kind == KIND_JUMP);

    pflsu_field_decode u_dec (
        .code       (field_i),
        .left       (left),
        .right      (right),
        .first_byte (first_byte),
        .legal      (legal)
    );

    // store operand: zero mode, short registers, jump sign
    always_comb begin
        st_src = reg_w;
        if (op == OP_STORE_ZERO) st_src = '0;
        if (short_reg) begin
            for (int p = 1; p <= NBYTES - IDX_BYTES; p++) st_src.b[p] = '0;
        end
        if (kind == KIND_JUMP) st_src.neg = 1'b0;
    end

    pflsu_load_extract u_ld (
        .src_w      (mem_w),
        .left       (left),
        .right      (right),
        .first_byte (first_byte),
        .negate     (op == OP_LOAD_NEG),
        .short_reg  (short_reg),
        .dst_w      (ld_w)
    );

    pflsu_store_merge u_st (
        .old_w      (mem_w),
        .src_w      (st_src),
        .left       (left),
        .right      (right),
        .first_byte (first_byte),
        .dst_w      (st_w)
    );

    always_comb begin
        if (legal) next_res = is_store ? st_w  : ld_w;
        else       next_res = is_store ? mem_w : reg_w;
    end

    // controller: next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_i ? ST_RESP : ST_IDLE;
        endcase
    end

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            err_q    <= 1'b0;
        end else if (req_i) begin
            result_q <= next_res;
            err_q    <= !legal;
        end
    end

    assign res_valid_o = (state_q == ST_RESP);
    assign result_o    = result_q;
    assign err_o       = err_q;

    // R11
    valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o == ($past(req_i) && $past(rst_n)));

    // R3
    load_plus_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !err_o && $past(op_i == 2'd0) && $past(field_i[5:3] != 3'd0))
        |-> !result_o[WORD_W-1]);

    // R4
    neg_load_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !err_o && $past(op_i == 2'd1) && $past(field_i[5:3] != 3'd0))
        |-> result_o[WORD_W-1]);

    // R6
    store_sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !err_o && $past(op_i[1]) && $past(field_i[5:3] != 3'd0))
        |-> result_o[WORD_W-1] == $past(mem_word_i[WORD_W-1]));

    // R8
    jump_plus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !err_o && $past(op_i == 2'd2) && $past(kind_i == 2'd2)
         && $past(field_i[5:3] == 3'd0))
        |-> !result_o[WORD_W-1]);

    // R10
    bad_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && err_o && $past(!op_i[1])) |-> result_o == $past(reg_word_i));

    // R10
    bad_store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && err_o && $past(op_i[1])) |-> result_o == $past(mem_word_i));
endmodule

// File: tb/pf_lsu_tb.sv
module pf_lsu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic [1:0]  kind_i = '0;
    logic [5:0]  field_i = '0;
    logic [30:0] mem_word_i = '0;
    logic [30:0] reg_word_i = '0;
    logic        res_valid_o;
    logic [30:0] result_o;
    logic        err_o;

    always #5 clk = ~clk;

    pf_lsu dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .op_i(op_i), .kind_i(kind_i),
        .field_i(field_i), .mem_word_i(mem_word_i), .reg_word_i(reg_word_i),
        .res_valid_o(res_valid_o), .result_o(result_o), .err_o(err_o)
    );

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;
    bit          exp_valid = 0;
    logic [30:0] exp_res = '0;
    bit          exp_err = 0;
    string       exp_tag = "R11";

    // behavioural model on integers: byte fields as powers of 64
    function automatic void model(input int op, input int kind, input int field,
                                  input logic [30:0] mem, input logic [30:0] rg,
                                  output logic [30:0] res, output bit err);
        int     l = field / 8;
        int     r = field % 8;
        int     lo, nb, sh;
        longint fmask, v, smag;
        bit     sg, ssg;
        bit     shortr = (kind == 1) || (kind == 2);
        if (l > r || r > 5) begin
            err = 1;
            res = (op >= 2) ? mem : rg;
            return;
        end
        err   = 0;
        lo    = (l == 0) ? 1 : l;
        nb    = r - lo + 1;
        sh    = 6 * (5 - r);
        fmask = ((longint'(1) << (6 * nb)) - 1) << sh;
        if (op < 2) begin
            v = (longint'(mem[29:0]) & fmask) >> sh;
            if (shortr) v = v & 'hFFF;
            sg = (l == 0) ? mem[30] : 1'b0;
            if (op == 1) sg = !sg;
            res = {sg, v[29:0]};
        end else begin
            smag = (op == 3) ? 0 : longint'(rg[29:0]);
            ssg  = (op == 3) ? 1'b0 : rg[30];
            if (shortr) smag = smag & 'hFFF;
            if (kind == 2) ssg = 1'b0;
            v  = (longint'(mem[29:0]) & ~fmask) | ((smag << sh) & fmask);
            sg = (l == 0) ? ssg : mem[30];
            res = {sg, v[29:0]};
        end
    endfunction

    task automatic check_outputs();
        n_run++;
        if (res_valid_o !== exp_valid || result_o !== exp_res || err_o !== exp_err) begin
            n_fail++;
            $display("FAIL %s actual valid=%0b result=%h err=%0b expected valid=%0b result=%h err=%0b",
                     exp_tag, res_valid_o, result_o, err_o, exp_valid, exp_res, exp_err);
        end
    endtask

    task automatic step(input bit rq, input int op, input int kind, input int field,
                        input string tag);
        logic [30:0] m, g, res;
        bit          e;
        @(negedge clk);
        check_outputs();
        m = 31'($urandom());
        g = 31'($urandom());
        req_i = rq; op_i = 2'(op); kind_i = 2'(kind); field_i = 6'(field);
        mem_word_i = m; reg_word_i = g;
        exp_valid = rq;
        if (rq) begin
            model(op, kind, field, m, g, res, e);
            exp_res = res;
            exp_err = e;
        end
        exp_tag = tag;
    endtask

    function automatic bit legal_code(input int f);
        return (f / 8 <= f % 8) && (f % 8 <= 5);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // first step checks the reset state (R11)
        for (int f = 0; f < 64; f++) step(1, 0, 0, f, "R1");
        for (int rep = 0; rep < 4; rep++)
            for (int f = 0; f < 64; f++)
                if (legal_code(f)) step(1, 0, 0, f, (f / 8 == 0) ? "R3" : "R2");
        for (int f = 0; f < 64; f++)
            if (legal_code(f)) step(1, 1, (f % 2) * 3, f, "R4");
        for (int rep = 0; rep < 4; rep++)
            for (int f = 0; f < 64; f++)
                if (legal_code(f)) step(1, 2, 0, f, (f / 8 == 0) ? "R6" : "R5");
        for (int f = 0; f < 64; f++)
            if (legal_code(f)) begin
                step(1, 0, 1, f, "R7");
                step(1, 2, 1, f, "R7");
                step(1, 1, 2, f, "R7");
            end
        for (int rep = 0; rep < 3; rep++)
            for (int f = 0; f < 64; f++)
                if (legal_code(f)) step(1, 2, 2, f, "R8");
        for (int f = 0; f < 64; f++)
            if (legal_code(f)) step(1, 3, f % 4, f, "R9");
        for (int f = 0; f < 64; f++)
            if (!legal_code(f))
                for (int op = 0; op < 4; op++) step(1, op, f % 4, f, "R10");
        for (int k = 0; k < 40; k++) begin
            step(1, k % 4, k % 3, k % 46, "R11");
            step(0, 0, 0, 0, "R11");
            step(0, 2, 1, 5, "R11");
        end
        @(negedge clk);
        check_outputs();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule